// File: doc/BRIEF.md
# Bypass I2C Register-Write Engine

This block is a small I2C master inside a power-management controller. Its only job is to push one byte into a register of an external regulator. Software fills a 32-bit command word with the regulator's 7-bit bus address, the target register index and the value. It then sets the go flag in that same word. The engine plays the complete write on the two open-drain wires and drops the go flag on its own once the STOP condition has been sent. Software polls that flag to learn that the write is over.

The SCL waveform comes from a timing register. That register holds a high count and a low count in system clocks. The wire then stays high for the high count plus five clocks and low for the low count plus seven clocks. A mode register keeps a few option bits for compatibility. Only standard/fast timing is generated. If an ACK slot finds the wire high, the engine stops the frame at once and records a sticky error bit.

Top module: `vreg_i2c_writer`

## Requirements
- R1: After a synchronous reset, both wires are released (`scl_oe` = 0, `sda_oe` = 0) and all four registers read 0.
- R2: Register 0 (command) holds the device address in bits 6:0, the register index in bits 15:8, the data byte in bits 23:16 and the go flag in bit 24. Bits 7 and 31:25 read 0.
- R3: Writing register 0 with bit 24 = 1 while the go flag is 0 sends the following on the bus: START, byte {address, 0}, register index, data, each MSB first and each followed by an ACK slot, then STOP.
- R4: The go flag (register 0 bit 24, mirrored in register 3 bit 1) reads 1 during the frame and clears itself with STOP. A command write with bit 24 = 0 only stores fields and puts nothing on the bus.
- R5: Every SCL high period lasts high count + 5 clocks and every low period lasts low count + 7 clocks. Register 1 bits 7:0 hold the high count and bits 15:8 the low count. The START hold and the STOP setup each last one high period.
- R6: SDA changes only while SCL is low, except at the START and STOP edges.
- R7: If SDA reads high in an ACK slot, the next action is STOP. After that STOP, no further byte is sent and the go flag clears. Register 3 bit 0 is then set and stays set until written with 1. Writing it with 0 leaves it set.
- R8: Writes to registers 0 and 1 while the go flag is 1 are ignored. The frame in progress is not affected.
- R9: Register 1 bits 31:16 are stored and read back but do not change the timing. Register 2 keeps only bits 1:0, 3, 4 and 6 (others read 0). Setting its bit 3 does not change the timing.
- R10: An SCL high period counts only the clocks in which `scl_in` reads high. A slave holding SCL low therefore lengthens the period.
- R11: `reg_rdata` shows the register selected by `reg_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 timing, 2 mode, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| scl_in | input | 1 | Sensed level of the SCL wire |
| sda_in | input | 1 | Sensed level of the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two things can meet in one clock: a software write to the command or timing register, and the engine being busy with a frame. The bench writes new fields, a second go request and new timing while a slow frame is running. It then reads both registers back and requires the old values. It also requires the bytes decoded from the wires and the measured SCL periods to match the original command. The sticky error bit is tested the same way. A clean frame sent after a NACK must leave the bit set, and only a write of 1 may clear it.

// File: rtl/vreg_i2c_pkg.sv
package vreg_i2c_pkg;
  localparam int REG_W     = 32;
  localparam int GO_BIT    = 24;
  localparam int NBYTES    = 3;
  localparam int BYTE_IW   = 2;
  localparam logic [REG_W-1:0] FIELD_MASK = 32'h00FF_FF7F;
  localparam logic [REG_W-1:0] MODE_MASK  = 32'h0000_005B;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_TIME = 2'd1,
    SEL_MODE = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_BIT_L,
    PH_BIT_H,
    PH_STOP_L,
    PH_STOP_H
  } phase_e;
endpackage

// File: rtl/vreg_i2c_timer.sv
module vreg_i2c_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (en && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/vreg_i2c_regs.sv
module vreg_i2c_regs
  import vreg_i2c_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             done,
  input  logic             nack_set,
  output logic             launch,
  output logic             go_flag,
  output logic             nack_flag,
  output logic [REG_W-1:0] cmd_word,
  output logic [REG_W-1:0] time_word,
  output logic [CNT_W-1:0] scl_hi,
  output logic [CNT_W-1:0] scl_lo
);
  logic [REG_W-1:0] cmd_q, time_q, mode_q, rd_mux, rdata_q;
  logic             go_q, nack_q;
  logic             wr_cmd, wr_time, wr_mode, wr_stat;

  assign wr_cmd  = reg_wr && (reg_sel_e'(reg_addr) == SEL_CMD);
  assign wr_time = reg_wr && (reg_sel_e'(reg_addr) == SEL_TIME);
  assign wr_mode = reg_wr && (reg_sel_e'(reg_addr) == SEL_MODE);
  assign wr_stat = reg_wr && (reg_sel_e'(reg_addr) == SEL_STAT);
  assign launch  = wr_cmd && !go_q && reg_wdata[GO_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      time_q <= '0;
      mode_q <= '0;
      go_q   <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      if (wr_cmd && !go_q) cmd_q <= reg_wdata & FIELD_MASK;
      if (wr_time && !go_q) time_q <= reg_wdata;
      if (wr_mode) mode_q <= reg_wdata & MODE_MASK;
      if (launch) go_q <= 1'b1;
      else if (done) go_q <= 1'b0;
      if (nack_set) nack_q <= 1'b1;
      else if (wr_stat && ((reg_wdata & 32'h1) != '0)) nack_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel_e'(reg_addr))
      SEL_CMD:  rd_mux = cmd_q | (REG_W'(go_q) << GO_BIT);
      SEL_TIME: rd_mux = time_q;
      SEL_MODE: rd_mux = mode_q;
      default:  rd_mux = {{(REG_W-2){1'b0}}, go_q, nack_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign go_flag   = go_q;
  assign nack_flag = nack_q;
  assign cmd_word  = cmd_q;
  assign time_word = time_q;
  assign scl_hi    = time_q[0 +: CNT_W];
  assign scl_lo    = time_q[8 +: CNT_W];
endmodule

// File: rtl/vreg_i2c_seq.sv
module vreg_i2c_seq
  import vreg_i2c_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int HI_OFS = 5,
  parameter int LO_OFS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       reg_idx,
  input  logic [7:0]       wr_data,
  input  logic [CNT_W-1:0] scl_hi,
  input  logic [CNT_W-1:0] scl_lo,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             done,
  output logic             nack_set
);
  localparam int PH_W = CNT_W + 1;

  phase_e             state_q;
  logic [3:0]         bit_q;
  logic [BYTE_IW-1:0] byte_q;
  logic               first_q, scl_q, sda_q;
  logic [7:0]         frame [2**BYTE_IW];
  logic [7:0]         cur_byte;
  logic [PH_W-1:0]    hi_ld, lo_ld, tmr_val;
  logic               tmr_load, tmr_en, tmr_zero;
  logic               high_phase, step, last_bit, last_byte;

  always_comb begin
    frame[0] = {dev_addr, 1'b0};
    frame[1] = reg_idx;
    frame[2] = wr_data;
    frame[3] = 8'h00;
  end
  assign cur_byte = frame[byte_q];

  assign hi_ld      = PH_W'(scl_hi) + PH_W'(HI_OFS - 1);
  assign lo_ld      = PH_W'(scl_lo) + PH_W'(LO_OFS - 1);
  assign high_phase = (state_q == PH_START) || (state_q == PH_BIT_H) || (state_q == PH_STOP_H);
  assign tmr_en     = !high_phase || scl_in;
  assign step       = tmr_zero && tmr_en;
  assign last_bit   = (bit_q == 4'd8);
  assign last_byte  = (byte_q == BYTE_IW'(NBYTES - 1));
  assign nack_set   = (state_q == PH_BIT_H) && step && last_bit && sda_in;
  assign done       = (state_q == PH_STOP_H) && step;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = lo_ld;
    case (state_q)
      PH_IDLE: begin
        tmr_load = launch;
        tmr_val  = hi_ld;
      end
      PH_START, PH_BIT_H: tmr_load = step;
      PH_BIT_L, PH_STOP_L: begin
        tmr_load = step;
        tmr_val  = hi_ld;
      end
      default: tmr_load = 1'b0;
    endcase
  end

  vreg_i2c_timer #(.W(PH_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .en       (tmr_en),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      first_q <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      case (state_q)
        PH_IDLE: if (launch) begin
          state_q <= PH_START;
          sda_q   <= 1'b1;
        end
        PH_START: if (step) begin
          state_q <= PH_BIT_L;
          scl_q   <= 1'b1;
          first_q <= 1'b1;
          bit_q   <= '0;
          byte_q  <= '0;
        end
        PH_BIT_L: begin
          if (first_q) begin
            first_q <= 1'b0;
            sda_q   <= last_bit ? 1'b0 : ~cur_byte[~bit_q[2:0]];
          end
          if (step) begin
            state_q <= PH_BIT_H;
            scl_q   <= 1'b0;
          end
        end
        PH_BIT_H: if (step) begin
          scl_q   <= 1'b1;
          first_q <= 1'b1;
          if (last_bit) begin
            if (sda_in || last_byte) begin
              state_q <= PH_STOP_L;
            end else begin
              state_q <= PH_BIT_L;
              byte_q  <= byte_q + 1'b1;
              bit_q   <= '0;
            end
          end else begin
            state_q <= PH_BIT_L;
            bit_q   <= bit_q + 1'b1;
          end
        end
        PH_STOP_L: begin
          if (first_q) begin
            first_q <= 1'b0;
            sda_q   <= 1'b1;
          end
          if (step) begin
            state_q <= PH_STOP_H;
            scl_q   <= 1'b0;
          end
        end
        PH_STOP_H: if (step) begin
          state_q <= PH_IDLE;
          sda_q   <= 1'b0;
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign scl_oe = scl_q;
  assign sda_oe = sda_q;
endmodule

// File: rtl/vreg_i2c_writer.sv
module vreg_i2c_writer
  import vreg_i2c_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int HI_OFS = 5,
  parameter int LO_OFS = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);
  logic             launch, go_flag, nack_flag, done, nack_set;
  logic [REG_W-1:0] cmd_word, time_word;
  logic [CNT_W-1:0] scl_hi, scl_lo;

  vreg_i2c_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .done      (done),
    .nack_set  (nack_set),
    .launch    (launch),
    .go_flag   (go_flag),
    .nack_flag (nack_flag),
    .cmd_word  (cmd_word),
    .time_word (time_word),
    .scl_hi    (scl_hi),
    .scl_lo    (scl_lo)
  );

  vreg_i2c_seq #(.CNT_W(CNT_W), .HI_OFS(HI_OFS), .LO_OFS(LO_OFS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .dev_addr (cmd_word[6:0]),
    .reg_idx  (cmd_word[15:8]),
    .wr_data  (cmd_word[23:16]),
    .scl_hi   (scl_hi),
    .scl_lo   (scl_lo),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .done     (done),
    .nack_set (nack_set)
  );
endmodule

// File: rtl/vreg_i2c_chk.sv
module vreg_i2c_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        go_flag,
  input logic        done,
  input logic        nack_flag,
  input logic [31:0] cmd_word,
  input logic [31:0] time_word,
  input logic        scl_oe,
  input logic        sda_oe
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !go_flag |-> (!scl_oe && !sda_oe)); // R4

  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (go_flag && $past(go_flag) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R6

  AST_DONE_CLEARS_GO: assert property (@(posedge clk) disable iff (rst)
    done |=> !go_flag); // R4

  AST_NACK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (nack_flag && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> nack_flag); // R7

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    go_flag |=> $stable(cmd_word)); // R8

  AST_TIME_FROZEN: assert property (@(posedge clk) disable iff (rst)
    go_flag |=> $stable(time_word)); // R8
endmodule

bind vreg_i2c_writer vreg_i2c_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .go_flag   (go_flag),
  .done      (done),
  .nack_flag (nack_flag),
  .cmd_word  (cmd_word),
  .time_word (time_word),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe)
);

// File: tb/test_vreg_i2c_writer.sv
`timescale 1ns/1ps
module test_vreg_i2c_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        scl_in, sda_in, scl_oe, sda_oe;

  int nvec = 0, nfail = 0, cyc = 0;
  int starts = 0, stops = 0, byteno = 0, bitcnt = 0, tmis = 0, stretched = 0;
  int hi_run = 0, lo_run = 0, exp_h = 5, exp_l = 7;
  logic [7:0] shreg = '0;
  logic [7:0] got [4];
  logic       ack_en [4];
  logic       slave_pull = 1'b0;
  logic       prev_scl = 1'b1, prev_sda = 1'b1;
  logic       stretch_en = 1'b0;
  int         stretch_len = 4;
  logic [7:0] stretch_cnt = '0;
  logic [31:0] cur_time = '0;
  logic       exp_nack = 1'b0;

  always #2 clk = ~clk;

  assign scl_in = !scl_oe && !(stretch_en && (int'(stretch_cnt) < stretch_len));
  assign sda_in = !(sda_oe || slave_pull);

  vreg_i2c_writer i_vreg_i2c_writer (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always @(posedge clk) begin
    if (scl_oe) stretch_cnt <= 8'd0;
    else if (stretch_cnt != 8'hFF) stretch_cnt <= stretch_cnt + 8'd1;
  end

  // Bus monitor and ACK-driving slave model
  always @(negedge clk) begin
    if (prev_scl && scl_in && prev_sda && !sda_in) begin
      starts++; bitcnt = 0; byteno = 0; hi_run = 1;
    end else if (prev_scl && scl_in && !prev_sda && sda_in) begin
      stops++;
      if (hi_run != exp_h) tmis++;
    end else if (!prev_scl && scl_in) begin
      if (lo_run != exp_l) tmis++;
      hi_run = 1;
      if (bitcnt < 8) shreg = {shreg[6:0], sda_in};
      bitcnt++;
    end else if (prev_scl && !scl_in) begin
      if (hi_run != exp_h) tmis++;
      lo_run = scl_oe ? 1 : 0;
      if (bitcnt == 8) begin
        got[byteno] = shreg;
        slave_pull = ack_en[byteno];
      end else if (bitcnt == 9) begin
        slave_pull = 1'b0; bitcnt = 0; byteno++;
      end
    end else if (scl_in) begin
      hi_run++;
    end else if (scl_oe) begin
      lo_run++;
    end
    if (!scl_in && !scl_oe) stretched++;
    prev_scl = scl_in;
    prev_sda = sda_in;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      nvec++; nfail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic set_time(input int hi, input int lo, input logic [15:0] hs);
    cur_time = {hs, 8'(lo), 8'(hi)};
    wr(2'd1, cur_time);
    exp_h = hi + 5;
    exp_l = lo + 7;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 60000; n++) begin
      rd(2'd3, s);
      if (!s[1]) return;
    end
    check("R4 go flag never cleared", 32'd1, 32'd0);
  endtask

  task automatic run_txn(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                         input int nack_at, input bit meddle);
    logic [31:0] s, v;
    logic [7:0]  expb [3];
    int nb, st, sp, bn, tm;
    expb[0] = {a, 1'b0}; expb[1] = r; expb[2] = d;
    @(posedge clk);
    starts = 0; stops = 0; byteno = 0; tmis = 0; stretched = 0;
    for (int k = 0; k < 4; k++) ack_en[k] = (k != nack_at);
    wr(2'd0, {8'h00, d, r, 1'b0, a});
    wr(2'd0, {7'h00, 1'b1, d, r, 1'b0, a});
    rd(2'd3, s);
    check("R4 go flag set during frame", 32'(s[1]), 32'd1);
    if (meddle) begin
      wr(2'd0, 32'h01A5_5A3C);
      wr(2'd1, 32'h0000_0101);
      rd(2'd0, v);
      check("R8 command write ignored", v, {7'h00, 1'b1, d, r, 1'b0, a});
      rd(2'd1, v);
      check("R8 timing write ignored", v, cur_time);
    end
    wait_idle();
    repeat (3) @(negedge clk);
    @(posedge clk);
    st = starts; sp = stops; bn = byteno; tm = tmis;
    if (nack_at < 3) exp_nack = 1'b1;
    nb = (nack_at < 3) ? nack_at + 1 : 3;
    check("R3 one START", 32'(st), 32'd1);
    check("R7 one STOP", 32'(sp), 32'd1);
    check("R3 R7 bytes on bus", 32'(bn), 32'(nb));
    for (int i = 0; i < nb; i++) check("R3 byte value", 32'(got[i]), 32'(expb[i]));
    check("R5 SCL period mismatches", 32'(tm), 32'd0);
    rd(2'd3, s);
    check("R7 status", s, {31'd0, exp_nack});
    rd(2'd0, v);
    check("R4 go flag self-cleared", v, {8'h00, d, r, 1'b0, a});
  endtask

  initial begin
    logic [31:0] v;
    int his [6] = '{0, 1, 0, 3, 40, 255};
    int los [6] = '{0, 0, 1, 9, 17, 255};
    for (int k = 0; k < 4; k++) begin ack_en[k] = 1'b1; got[k] = '0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 scl_oe", 32'(scl_oe), 32'd0);
    check("R1 sda_oe", 32'(sda_oe), 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 register reset", v, 32'd0);
    end

    // R11 read latency
    wr(2'd1, 32'h1234_0A0B);
    rd(2'd2, v);
    @(negedge clk); reg_addr = 2'd1;
    check("R11 old data before edge", reg_rdata, 32'd0);
    @(negedge clk);
    check("R11 data one clock later", reg_rdata, 32'h1234_0A0B);

    // R2 field layout, R4 no launch with go flag 0
    @(posedge clk); starts = 0;
    wr(2'd0, 32'hFE12_34F5);
    rd(2'd0, v);
    check("R2 command fields", v, 32'h0012_3475);
    repeat (30) @(negedge clk);
    @(posedge clk);
    check("R4 no frame without go", 32'(starts), 32'd0);
    rd(2'd3, v);
    check("R4 idle status", v, 32'd0);

    // R5 timing sweep
    for (int t = 0; t < 6; t++) begin
      set_time(his[t], los[t], 16'h0000);
      run_txn(7'h48 + 7'(t), 8'h10 + 8'(t), 8'hA5 ^ 8'(t), 3, 1'b0);
    end

    // R3 data sweep
    set_time(0, 0, 16'h0000);
    for (int i = 0; i < 48; i++)
      run_txn(7'((i * 29 + 5) & 127), 8'((i * 53 + 17) & 255), 8'(~(i * 11)), 3, 1'b0);
    run_txn(7'h7F, 8'hFF, 8'hFF, 3, 1'b0);
    run_txn(7'h00, 8'h00, 8'h00, 3, 1'b0);

    // R7 NACK in each slot, sticky bit and clear
    set_time(2, 3, 16'h0000);
    for (int k = 0; k < 3; k++) begin
      run_txn(7'h2C, 8'h3D, 8'h4E, k, 1'b0);
      run_txn(7'h2D, 8'h5E, 8'h6F, 3, 1'b0);
      wr(2'd3, 32'h0000_0000);
      rd(2'd3, v);
      check("R7 write 0 keeps error", v, 32'd1);
      wr(2'd3, 32'h0000_0001);
      exp_nack = 1'b0;
      rd(2'd3, v);
      check("R7 write 1 clears error", v, 32'd0);
    end

    // R8 writes during a frame
    set_time(10, 10, 16'h0000);
    run_txn(7'h12, 8'h34, 8'h56, 3, 1'b1);
    rd(2'd1, v);
    check("R8 timing kept after frame", v, cur_time);

    // R9 high-speed fields and mode bits
    set_time(2, 4, 16'hAA55);
    rd(2'd1, v);
    check("R9 high-speed counts stored", v, 32'hAA55_0402);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v);
    check("R9 mode bits kept", v, 32'h0000_005B);
    run_txn(7'h33, 8'hC3, 8'h3C, 3, 1'b0);

    // R10 clock stretching
    @(posedge clk); stretch_en = 1'b1; stretch_len = 4;
    set_time(1, 2, 16'h0000);
    run_txn(7'h61, 8'h92, 8'h0F, 3, 1'b0);
    @(posedge clk);
    check("R10 stretch observed", 32'(stretched > 0), 32'd1);
    stretch_en = 1'b0;

    summary();
  end
endmodule